// File: doc/BRIEF.md
# Layer Schedule Sequencer with Split Read and Write-Back Orders

This block is the control sequencer for a pipelined, layered decoder of quasi-cyclic low-density parity-check codes. It walks through the layers of the parity-check matrix in an order held in a programmable table. Each layer is a group of circulant block columns. For every block it issues one LLR-memory read per cycle. A fixed number of cycles later it issues the matching write-back. Each layer has its own read order and its own write-back order. A schedule can therefore read the blocks that do not overlap the previous layer first, and write back the blocks shared with the next layer first.

Reads and write-backs inside a layer follow different orders, so the intermediate variable-to-check values cannot sit in a FIFO. The sequencer gives random-access addresses for that buffer on both sides. It also tracks the columns whose update is still in the pipeline. When a read arrives before the value it needs has been written back, the read is flagged so that the datapath can patch it. After the last read of an iteration the sequencer waits for the pipeline to drain, then opens a one-cycle check window. It stops when the syndrome-zero input is high in that window or when the iteration limit is reached. Otherwise it starts the next iteration.

The schedule tables are written through a small configuration port while the sequencer is idle or finished.

Top module: `ldpc_layer_seq`

## Requirements
- R1: After reset, done, iter_end, rd_valid and wr_valid are 0 and iter_cnt is 0.
- R2: A start pulse in the idle or done state starts iteration 1 in the next cycle. Reads then issue on consecutive cycles: position p (0..NUM_LAYERS-1) of the order table selects the layer, and slots 0..DEG-1 of that layer's read table are issued in slot order. rd_layer, rd_col, rd_shift and rd_ovl come from the selected entry. Configuration: cfg_kind 0 sets order position cfg_addr to cfg_word[LAYER_W-1:0]. cfg_kind 1 sets read entry (layer cfg_addr, slot cfg_slot) to column cfg_word[COL_W-1:0], shift cfg_word[COL_W+SHIFT_W-1:COL_W] and overlap bit cfg_word[COL_W+SHIFT_W].
- R3: Every read is followed by exactly one write-back PIPE_LAT cycles later. The k-th write-back of a layer uses the layer's write-order entry k, which names a read slot. wr_col and wr_shift are that slot's column and shift. cfg_kind 2 sets write-order entry (layer cfg_addr, index cfg_slot) to read slot cfg_word[SLOT_W-1:0].
- R4: The variable-to-check buffer address is (p mod 2) * 2^SLOT_W + slot. On a read, v2c_wr_addr uses the read slot. On a write-back, v2c_rd_addr uses the read slot named by the write-order entry.
- R5: rd_conflict is 1 on a read exactly when its column has earlier reads whose write-backs have not yet issued. A write-back of that column in the same cycle counts as issued.
- R6: After the last read of an iteration, the pipeline drains. iter_end is high for one cycle, NUM_LAYERS*DEG+PIPE_LAT cycles after the iteration's first read. If decoding continues, the next iteration's first read follows in the next cycle and iter_cnt rises by one.
- R7: syn_zero is sampled only in the iter_end cycle. When it is high there, done rises in the next cycle and no further reads issue. syn_zero at any other time has no effect.
- R8: When iteration MAX_ITER ends, done rises in the next cycle whatever the value of syn_zero, and iter_cnt holds MAX_ITER.
- R9: done and iter_cnt hold without strobes until the next start pulse. That pulse restarts from iteration 1.
- R10: While a run is in progress (reading, draining or checking), cfg_we and start have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; accepted only when idle or done |
| syn_zero | input | 1 | Syndrome-zero indication, sampled in the iter_end cycle |
| cfg_we | input | 1 | Schedule table write enable |
| cfg_kind | input | 2 | Table select: 0 order, 1 read entry, 2 write-order entry |
| cfg_addr | input | LAYER_W | Order position or layer number |
| cfg_slot | input | SLOT_W | Slot within the layer |
| cfg_word | input | COL_W+SHIFT_W+1 | Entry data |
| rd_valid | output | 1 | A read block is issued this cycle |
| rd_layer | output | LAYER_W | Layer of the read |
| rd_col | output | COL_W | LLR-memory word (circulant column) to read |
| rd_shift | output | SHIFT_W | Cyclic shift of the read block |
| rd_ovl | output | 1 | Overlap bit of the read entry |
| rd_conflict | output | 1 | Read precedes a pending write-back of the same column |
| v2c_wr_addr | output | SLOT_W+1 | Variable-to-check buffer write address |
| wr_valid | output | 1 | A write-back block is issued this cycle |
| wr_col | output | COL_W | LLR-memory word to write back |
| wr_shift | output | SHIFT_W | Cyclic shift of the write-back block |
| v2c_rd_addr | output | SLOT_W+1 | Variable-to-check buffer read address |
| iter_end | output | 1 | One-cycle end-of-iteration check window |
| iter_cnt | output | ITER_W | Current or final iteration number |
| done | output | 1 | Decoding finished |

## Verification
The properties assume that start and syn_zero are clean synchronous levels. They also assume that the loaded schedule is well formed: every order position names a valid layer, each layer's columns are distinct and below NUM_COLS, and each write-order row is a permutation of the read slots. The stimulus loads only schedules built arithmetically with those properties, and changes its inputs only at falling edges. The bench deliberately raises syn_zero during the reading and draining cycles of later iterations, so the claim that syn_zero is sampled only in the check window is tested at the ports.

// File: rtl/ldpc_seq_pkg.sv
package ldpc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RUN   = 3'd1,
    S_DRAIN = 3'd2,
    S_CHECK = 3'd3,
    S_DONE  = 3'd4
  } seq_state_e;

  localparam logic [1:0] CFG_ORDER = 2'd0;
  localparam logic [1:0] CFG_READ  = 2'd1;
  localparam logic [1:0] CFG_WORD  = 2'd2;

  // buffer address: parity of order position above the slot index
  function automatic int unsigned v2c_addr(input int unsigned parity,
                                           input int unsigned slot,
                                           input int unsigned slot_w);
    return ((parity & 1) << slot_w) | slot;
  endfunction

  // outstanding-write counter update
  function automatic int unsigned pend_next(input int unsigned cur,
                                            input bit inc, input bit dec);
    return cur + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction

  // end-of-iteration decision
  function automatic bit stop_now(input bit syn, input int unsigned iter,
                                  input int unsigned max_iter);
    return syn || (iter >= max_iter);
  endfunction

endpackage

// File: rtl/ldpc_seq_table.sv
module ldpc_seq_table
  import ldpc_seq_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int DEG        = 3,
  parameter int COL_W      = 3,
  parameter int SHIFT_W    = 5,
  parameter int LAYER_W    = 2,
  parameter int SLOT_W     = 2,
  localparam int CFG_W     = COL_W + SHIFT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic [1:0]         cfg_kind,
  input  logic [LAYER_W-1:0] cfg_addr,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic [CFG_W-1:0]   cfg_word,
  input  logic [LAYER_W-1:0] rd_pos,
  input  logic [SLOT_W-1:0]  rd_slot,
  output logic [LAYER_W-1:0] rd_layer,
  output logic [COL_W-1:0]   rd_col,
  output logic [SHIFT_W-1:0] rd_shift,
  output logic               rd_ovl,
  input  logic [LAYER_W-1:0] wr_layer,
  input  logic [SLOT_W-1:0]  wr_kslot,
  output logic [SLOT_W-1:0]  wr_src,
  output logic [COL_W-1:0]   wr_col,
  output logic [SHIFT_W-1:0] wr_shift
);

  logic [LAYER_W-1:0] order_q [NUM_LAYERS];
  logic [COL_W-1:0]   col_q   [NUM_LAYERS][DEG];
  logic [SHIFT_W-1:0] shift_q [NUM_LAYERS][DEG];
  logic               ovl_q   [NUM_LAYERS][DEG];
  logic [SLOT_W-1:0]  perm_q  [NUM_LAYERS][DEG];

  genvar gl, gs;
  generate
    for (gl = 0; gl < NUM_LAYERS; gl++) begin : g_layer
      logic hit_order, hit_layer;
      assign hit_order = cfg_en && (cfg_kind == CFG_ORDER) &&
                         (cfg_addr == LAYER_W'(gl));
      assign hit_layer = cfg_en && (cfg_addr == LAYER_W'(gl));

      always_ff @(posedge clk) begin
        if (!rst_n)         order_q[gl] <= LAYER_W'(gl);
        else if (hit_order) order_q[gl] <= cfg_word[LAYER_W-1:0];
      end

      for (gs = 0; gs < DEG; gs++) begin : g_slot
        logic hit_slot;
        assign hit_slot = hit_layer && (cfg_slot == SLOT_W'(gs));

        always_ff @(posedge clk) begin
          if (!rst_n) begin
            col_q[gl][gs]   <= '0;
            shift_q[gl][gs] <= '0;
            ovl_q[gl][gs]   <= 1'b0;
            perm_q[gl][gs]  <= SLOT_W'(gs);
          end else if (hit_slot) begin
            if (cfg_kind == CFG_READ) begin
              col_q[gl][gs]   <= cfg_word[COL_W-1:0];
              shift_q[gl][gs] <= cfg_word[COL_W +: SHIFT_W];
              ovl_q[gl][gs]   <= cfg_word[COL_W+SHIFT_W];
            end else if (cfg_kind == CFG_WORD) begin
              perm_q[gl][gs]  <= cfg_word[SLOT_W-1:0];
            end
          end
        end
      end
    end
  endgenerate

  always_comb begin
    rd_layer = order_q[rd_pos];
    rd_col   = col_q[rd_layer][rd_slot];
    rd_shift = shift_q[rd_layer][rd_slot];
    rd_ovl   = ovl_q[rd_layer][rd_slot];
    wr_src   = perm_q[wr_layer][wr_kslot];
    wr_col   = col_q[wr_layer][wr_src];
    wr_shift = shift_q[wr_layer][wr_src];
  end

endmodule

// File: rtl/ldpc_seq_dly.sv
module ldpc_seq_dly #(
  parameter int DEPTH = 3,
  parameter int W     = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic [DEPTH-1:0]        v_q;
  logic [DEPTH-1:0][W-1:0] d_q;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            v_q[0] <= 1'b0;
            d_q[0] <= '0;
          end else begin
            v_q[0] <= in_valid;
            d_q[0] <= in_data;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            v_q[g] <= 1'b0;
            d_q[g] <= '0;
          end else begin
            v_q[g] <= v_q[g-1];
            d_q[g] <= d_q[g-1];
          end
        end
      end
    end
  endgenerate

  assign out_valid = v_q[DEPTH-1];
  assign out_data  = d_q[DEPTH-1];

endmodule

// File: rtl/ldpc_seq_hazard.sv
module ldpc_seq_hazard
  import ldpc_seq_pkg::*;
#(
  parameter int NUM_COLS = 6,
  parameter int COL_W    = 3,
  parameter int PEND_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire,
  input  logic [COL_W-1:0] rd_col,
  input  logic             wr_fire,
  input  logic [COL_W-1:0] wr_col,
  output logic             conflict,
  output logic             pend_full
);

  logic [NUM_COLS-1:0] busy_v;
  logic [NUM_COLS-1:0] full_v;

  genvar g;
  generate
    for (g = 0; g < NUM_COLS; g++) begin : g_col
      logic [PEND_W-1:0] pend_q;
      logic inc, dec;
      assign inc = rd_fire && (rd_col == COL_W'(g));
      assign dec = wr_fire && (wr_col == COL_W'(g));
      // a same-cycle write-back of this column counts as delivered
      assign busy_v[g] = (pend_q - PEND_W'(dec)) != '0;
      assign full_v[g] = &pend_q;

      always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= PEND_W'(pend_next(int'(pend_q), inc, dec));
      end
    end
  endgenerate

  always_comb begin
    conflict = 1'b0;
    for (int c = 0; c < NUM_COLS; c++)
      if (rd_fire && (rd_col == COL_W'(c)) && busy_v[c]) conflict = 1'b1;
  end

  assign pend_full = |full_v;

endmodule

// File: rtl/ldpc_layer_seq.sv
module ldpc_layer_seq
  import ldpc_seq_pkg::*;
#(
  parameter int NUM_LAYERS = 4,
  parameter int DEG        = 3,
  parameter int NUM_COLS   = 6,
  parameter int SHIFT_W    = 5,
  parameter int PIPE_LAT   = 3,
  parameter int MAX_ITER   = 10,
  localparam int LAYER_W   = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
  localparam int SLOT_W    = (DEG > 1) ? $clog2(DEG) : 1,
  localparam int COL_W     = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int ITER_W    = $clog2(MAX_ITER + 1),
  localparam int AW        = SLOT_W + 1,
  localparam int CFG_W     = COL_W + SHIFT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               syn_zero,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_kind,
  input  logic [LAYER_W-1:0] cfg_addr,
  input  logic [SLOT_W-1:0]  cfg_slot,
  input  logic [CFG_W-1:0]   cfg_word,
  output logic               rd_valid,
  output logic [LAYER_W-1:0] rd_layer,
  output logic [COL_W-1:0]   rd_col,
  output logic [SHIFT_W-1:0] rd_shift,
  output logic               rd_ovl,
  output logic               rd_conflict,
  output logic [AW-1:0]      v2c_wr_addr,
  output logic               wr_valid,
  output logic [COL_W-1:0]   wr_col,
  output logic [SHIFT_W-1:0] wr_shift,
  output logic [AW-1:0]      v2c_rd_addr,
  output logic               iter_end,
  output logic [ITER_W-1:0]  iter_cnt,
  output logic               done
);

  localparam int PEND_W  = $clog2(PIPE_LAT + 2);
  localparam int DRAIN_W = (PIPE_LAT > 1) ? $clog2(PIPE_LAT) : 1;
  localparam int DLY_W   = 1 + LAYER_W + SLOT_W;

  seq_state_e         state_q;
  logic [LAYER_W-1:0] pos_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [ITER_W-1:0]  iter_q;
  logic [DRAIN_W-1:0] drain_q;

  // named internal events
  logic ev_idle, ev_go, ev_slot_last, ev_pos_last, ev_drain_last, ev_stop;
  logic pend_full;

  assign ev_idle       = (state_q == S_IDLE) || (state_q == S_DONE);
  assign ev_go         = start && ev_idle;
  assign ev_slot_last  = (slot_q == SLOT_W'(DEG - 1));
  assign ev_pos_last   = (pos_q == LAYER_W'(NUM_LAYERS - 1));
  assign ev_drain_last = (drain_q == '0);
  assign ev_stop       = stop_now(syn_zero, int'(iter_q), MAX_ITER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pos_q   <= '0;
      slot_q  <= '0;
      iter_q  <= '0;
      drain_q <= '0;
    end else begin
      case (state_q)
        S_IDLE, S_DONE: begin
          if (ev_go) begin
            state_q <= S_RUN;
            pos_q   <= '0;
            slot_q  <= '0;
            iter_q  <= ITER_W'(1);
          end
        end
        S_RUN: begin
          if (ev_slot_last) begin
            slot_q <= '0;
            if (ev_pos_last) begin
              pos_q   <= '0;
              state_q <= S_DRAIN;
              drain_q <= DRAIN_W'(PIPE_LAT - 1);
            end else begin
              pos_q <= pos_q + 1'b1;
            end
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        S_DRAIN: begin
          if (ev_drain_last) state_q <= S_CHECK;
          else               drain_q <= drain_q - 1'b1;
        end
        S_CHECK: begin
          if (ev_stop) begin
            state_q <= S_DONE;
          end else begin
            state_q <= S_RUN;
            iter_q  <= iter_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_valid = (state_q == S_RUN);
  assign iter_end = (state_q == S_CHECK);
  assign done     = (state_q == S_DONE);
  assign iter_cnt = iter_q;

  // schedule storage
  logic [LAYER_W-1:0] wr_layer;
  logic [SLOT_W-1:0]  wr_kslot, wr_src;
  logic               wr_par;

  ldpc_seq_table #(
    .NUM_LAYERS(NUM_LAYERS), .DEG(DEG), .COL_W(COL_W),
    .SHIFT_W(SHIFT_W), .LAYER_W(LAYER_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_we && ev_idle),
    .cfg_kind (cfg_kind),
    .cfg_addr (cfg_addr),
    .cfg_slot (cfg_slot),
    .cfg_word (cfg_word),
    .rd_pos   (pos_q),
    .rd_slot  (slot_q),
    .rd_layer (rd_layer),
    .rd_col   (rd_col),
    .rd_shift (rd_shift),
    .rd_ovl   (rd_ovl),
    .wr_layer (wr_layer),
    .wr_kslot (wr_kslot),
    .wr_src   (wr_src),
    .wr_col   (wr_col),
    .wr_shift (wr_shift)
  );

  // read-to-write-back delay line
  logic [DLY_W-1:0] dly_in, dly_out;
  assign dly_in = {pos_q[0], rd_layer, slot_q};

  ldpc_seq_dly #(.DEPTH(PIPE_LAT), .W(DLY_W)) u_dly (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rd_valid),
    .in_data   (dly_in),
    .out_valid (wr_valid),
    .out_data  (dly_out)
  );

  assign {wr_par, wr_layer, wr_kslot} = dly_out;

  assign v2c_wr_addr = AW'(v2c_addr(int'(pos_q[0]), int'(slot_q), SLOT_W));
  assign v2c_rd_addr = AW'(v2c_addr(int'(wr_par), int'(wr_src), SLOT_W));

  // outstanding write-back tracking
  ldpc_seq_hazard #(.NUM_COLS(NUM_COLS), .COL_W(COL_W), .PEND_W(PEND_W)) u_hazard (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_valid),
    .rd_col    (rd_col),
    .wr_fire   (wr_valid),
    .wr_col    (wr_col),
    .conflict  (rd_conflict),
    .pend_full (pend_full)
  );

endmodule

// File: rtl/ldpc_layer_seq_chk.sv
module ldpc_layer_seq_chk #(
  parameter int MAX_ITER = 10,
  parameter int ITER_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              syn_zero,
  input logic              rd_valid,
  input logic              wr_valid,
  input logic              rd_conflict,
  input logic              iter_end,
  input logic [ITER_W-1:0] iter_cnt,
  input logic              done,
  input logic              pend_full
);

  logic quiet;
  assign quiet = !rd_valid && !wr_valid && !iter_end;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (quiet && !done && iter_cnt == '0));

  p_start_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && quiet) |=> (rd_valid && iter_cnt == ITER_W'(1)));

  p_conflict_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_conflict |-> rd_valid);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_full);

  p_iter_end_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    iter_end |=> !iter_end);

  p_continue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_end && !syn_zero && iter_cnt < ITER_W'(MAX_ITER))
      |=> (rd_valid && iter_cnt == $past(iter_cnt) + 1'b1));

  p_stop_syn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_end && syn_zero) |=> done);

  p_iter_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    iter_cnt <= ITER_W'(MAX_ITER));

  p_stop_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_end && iter_cnt == ITER_W'(MAX_ITER)) |=> done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> quiet);

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(iter_cnt)));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && start) |=> !done);

endmodule

bind ldpc_layer_seq ldpc_layer_seq_chk #(.MAX_ITER(MAX_ITER), .ITER_W(ITER_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .syn_zero    (syn_zero),
  .rd_valid    (rd_valid),
  .wr_valid    (wr_valid),
  .rd_conflict (rd_conflict),
  .iter_end    (iter_end),
  .iter_cnt    (iter_cnt),
  .done        (done),
  .pend_full   (pend_full)
);

// File: tb/tb_ldpc_layer_seq.sv
module tb_ldpc_layer_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NL  = 4;
  localparam int D   = 3;
  localparam int NC  = 6;
  localparam int SW  = 5;
  localparam int P   = 3;
  localparam int MI  = 10;
  localparam int LW  = 2;
  localparam int SLW = 2;
  localparam int CW  = 3;
  localparam int IW  = 4;
  localparam int AW  = 3;
  localparam int LD  = NL * D;
  localparam int T   = LD + P + 1;

  logic clk = 1'b0;
  logic rst_n, start, syn_zero, cfg_we;
  logic [1:0] cfg_kind;
  logic [LW-1:0] cfg_addr;
  logic [SLW-1:0] cfg_slot;
  logic [CW+SW:0] cfg_word;
  logic rd_valid, rd_ovl, rd_conflict, wr_valid, iter_end, done;
  logic [LW-1:0] rd_layer;
  logic [CW-1:0] rd_col, wr_col;
  logic [SW-1:0] rd_shift, wr_shift;
  logic [AW-1:0] v2c_wr_addr, v2c_rd_addr;
  logic [IW-1:0] iter_cnt;

  int n_total = 0;
  int n_fail  = 0;

  int b_order [NL];
  int b_col   [NL][D];
  int b_shift [NL][D];
  int b_ovl   [NL][D];
  int b_perm  [NL][D];

  always #(CLK_PERIOD/2) clk = ~clk;

  ldpc_layer_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .syn_zero(syn_zero),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_addr(cfg_addr),
    .cfg_slot(cfg_slot), .cfg_word(cfg_word),
    .rd_valid(rd_valid), .rd_layer(rd_layer), .rd_col(rd_col),
    .rd_shift(rd_shift), .rd_ovl(rd_ovl), .rd_conflict(rd_conflict),
    .v2c_wr_addr(v2c_wr_addr), .wr_valid(wr_valid), .wr_col(wr_col),
    .wr_shift(wr_shift), .v2c_rd_addr(v2c_rd_addr), .iter_end(iter_end),
    .iter_cnt(iter_cnt), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rdcol(input int k);
    int lay = b_order[k / D];
    return b_col[lay][k % D];
  endfunction

  function automatic int wrcol(input int k);
    int lay = b_order[k / D];
    return b_col[lay][b_perm[lay][k % D]];
  endfunction

  // pending count of a read's column after this cycle's write-back
  function automatic int conf_exp(input int k);
    int c = rdcol(k);
    int cnt = 0;
    for (int j = 0; j < k; j++) if (rdcol(j) == c) cnt++;
    for (int w = P; w <= k; w++) if (w - P < LD && wrcol(w - P) == c) cnt--;
    return (cnt != 0) ? 1 : 0;
  endfunction

  task automatic cfg_put(input int kind, input int addr, input int slot, input int word);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_addr = LW'(addr);
    cfg_slot = SLW'(slot); cfg_word = (CW+SW+1)'(word);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input int v);
    for (int p = 0; p < NL; p++) begin
      case (v)
        0: b_order[p] = p;
        1: b_order[p] = (p == 1) ? 2 : (p == 2) ? 1 : p;
        default: b_order[p] = (p * 3 + 3) % NL;
      endcase
      cfg_put(0, p, 0, b_order[p]);
    end
    for (int l = 0; l < NL; l++)
      for (int s = 0; s < D; s++) begin
        b_col[l][s]   = ((v + 1) * l + s) % NC;
        b_shift[l][s] = (l * 7 + s * 3 + v * 5) % 32;
        b_ovl[l][s]   = (s == D - 1) ? 1 : 0;
        b_perm[l][s]  = (v == 0) ? s : (v == 1) ? (D - 1 - s) : ((s + 1) % D);
        cfg_put(1, l, s, (b_ovl[l][s] << (CW + SW)) | (b_shift[l][s] << CW) | b_col[l][s]);
        cfg_put(2, l, s, b_perm[l][s]);
      end
  endtask

  task automatic run(input int stop_it, input bit disturb);
    int last = (stop_it < MI) ? stop_it : MI;
    string sq = (stop_it <= MI) ? "R7" : "R8";
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int it = 1; it <= last; it++)
      for (int c = 0; c < T; c++) begin
        string rq = (disturb && it == 1 && c > 1) ? "R10" : "R2";
        syn_zero = (it >= stop_it);
        if (disturb && it == 1) begin
          cfg_we   = (c == 1);
          cfg_kind = 2'd0; cfg_addr = '0;
          cfg_word = (CW+SW+1)'((b_order[0] + 1) % NL);
          start    = (c == 4);
        end
        chk("R6", "iter_cnt", iter_cnt, it);
        if (it == 1 && c == 0) chk("R9", "restart iter_cnt", iter_cnt, 1);
        chk("R6", "iter_end", iter_end, (c == LD + P));
        chk(sq, "done while running", done, 0);
        chk(rq, "rd_valid", rd_valid, (c < LD));
        if (c < LD) begin
          int p = c / D, s = c % D, lay = b_order[c / D];
          chk(rq, "rd_layer", rd_layer, lay);
          chk(rq, "rd_col", rd_col, b_col[lay][s]);
          chk(rq, "rd_shift", rd_shift, b_shift[lay][s]);
          chk(rq, "rd_ovl", rd_ovl, b_ovl[lay][s]);
          chk("R4", "v2c_wr_addr", v2c_wr_addr, ((p % 2) << SLW) | s);
          chk("R5", "rd_conflict", rd_conflict, conf_exp(c));
        end
        chk("R3", "wr_valid", wr_valid, (c >= P && c < LD + P));
        if (c >= P && c < LD + P) begin
          int k = c - P;
          int p = k / D, lay = b_order[k / D];
          int src = b_perm[lay][k % D];
          chk("R3", "wr_col", wr_col, b_col[lay][src]);
          chk("R3", "wr_shift", wr_shift, b_shift[lay][src]);
          chk("R4", "v2c_rd_addr", v2c_rd_addr, ((p % 2) << SLW) | src);
        end
        @(negedge clk);
      end
    cfg_we = 1'b0; start = 1'b0;
    for (int q = 0; q < 3; q++) begin
      syn_zero = q[0];
      chk(sq, "done", done, 1);
      chk(sq, "final iter_cnt", iter_cnt, last);
      chk("R9", "no read after done", rd_valid, 0);
      chk("R9", "no write after done", wr_valid, 0);
      chk("R9", "no iter_end after done", iter_end, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; syn_zero = 1'b0; cfg_we = 1'b0;
    cfg_kind = '0; cfg_addr = '0; cfg_slot = '0; cfg_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "done", done, 0);
    chk("R1", "iter_cnt", iter_cnt, 0);
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "wr_valid", wr_valid, 0);
    chk("R1", "iter_end", iter_end, 0);
    load(0);
    run(3, 1'b0);
    run(99, 1'b0);
    load(1);
    run(1, 1'b1);
    run(5, 1'b0);
    load(2);
    run(99, 1'b1);
    run(MI, 1'b0);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule